// File: doc/BRIEF.md
# System Clock Controller with PLL Lock Wait and Power Gear

This block produces the system clock of a processor subsystem from a high-speed oscillator clock. It drives the enable and multiplier-select lines of an external PLL (times 6 or times 8). After the PLL is enabled, it waits out a fixed lock-up time and raises a readable lock flag. Software polls that flag before it moves the system clock from the oscillator to the PLL output. The selected clock then passes through a power-saving gear that divides it by 1, 2, 4 or 8.

Software reaches the block through a single-cycle register port clocked by the oscillator. One write sets the gear, the multiplier, the PLL enable and the source select together. The read port returns these fields and the lock flag.

Both the source change and the gear change wait until the old and the new clock are low, so the output never carries a runt pulse. When the PLL enable is cleared while the PLL drives the output, the PLL is kept running until the handover back to the oscillator has completed.

Top module: `sysclk_gear_ctrl`

## Requirements
- R1: After reset, rd_data reads 0, pll_on is 0, and sys_clk runs at the oscillator frequency (gear divide-by-1, oscillator source).
- R2: Gear field wr_data[2:0] codes 000, 001, 010 and 011 divide the selected clock by 1, 2, 4 and 8 respectively.
- R3: Gear codes 100 to 111 are reserved and divide by 1.
- R4: Lock flag rd_data[6] reads 0 for 4095 oscillator cycles after the write edge that sets the PLL enable bit wr_data[4]. It reads 1 from cycle 4096 on, while the enable stays set.
- R5: With the lock flag at 1, a write of source-select bit wr_data[5] = 1 (with enable = 1) moves sys_clk onto the PLL clock. Multiplier bit wr_data[3] selects times 6 (0) or times 8 (1) and is driven on pll_mul8.
- R6: A write with source-select = 1 while the lock flag is 0 is ignored: rd_data[5] stays 0 and sys_clk stays on the oscillator.
- R7: A write with enable = 0 clears the lock flag, the lock counter and the source select at that edge, and returns sys_clk to the oscillator. pll_on falls once the handover has finished. A later re-enable waits the full 4096 cycles again.
- R8: No phase of sys_clk, high or low, is shorter than half a period of the fastest clock in use, across every gear and source change.
- R9: rd_data[5:0] reads back gear [2:0], multiplier [3], enable [4] and the accepted source select [5]. rd_data[6] is the read-only lock flag.
- R10: pll_on is 1 whenever the enable field reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | High-speed oscillator clock; clocks the register port and the lock counter |
| pll_clk | input | 1 | Multiplied clock from the external PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one osc_clk cycle |
| wr_data | input | 6 | Write fields: gear [2:0], multiplier [3], enable [4], source select [5] |
| rd_data | output | 7 | Read fields: the six written fields plus lock flag [6] |
| pll_on | output | 1 | PLL run request (enable field, held until the PLL path is released) |
| pll_mul8 | output | 1 | PLL multiplier select: 0 = times 6, 1 = times 8 |
| sys_clk | output | 1 | Divided system clock |

## Verification
Register fields read back at the first falling oscillator edge after the write edge. The bench samples them there. The lock flag is due exactly 4096 rising oscillator edges after the enabling write edge, so the bench counts 4095 edges and expects 0, then one more edge and expects 1. A gear or source change reaches sys_clk only after a two-stage synchronizer, a wait for the divider to wrap and, for a source change, a cross-domain handshake. For that reason every frequency check first lets 30 oscillator cycles pass and then times two consecutive rising edges of sys_clk against a period computed from the gear, the source and the multiplier. A monitor timestamps every sys_clk transition for the whole run, so a short phase is caught whenever it happens.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

   localparam int GEAR_W = 3;
   localparam int CFG_W  = 6;
   localparam int RD_W   = CFG_W + 1;

   // Field order is what the register port exposes: bit 5 down to bit 0.
   typedef struct packed {
      logic              sel_pll;
      logic              pll_en;
      logic              mul8;
      logic [GEAR_W-1:0] gear;
   } cfg_t;

endpackage

// File: rtl/sgc_cfg_regs.sv
module sgc_cfg_regs
   import sgc_pkg::*;
#(
   parameter int LOCK_STAGES = 12
) (
   input  logic             osc_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output cfg_t             cfg,
   output logic             lock
);

   if (LOCK_STAGES < 2) begin : g_bad_stages
      $error("sgc_cfg_regs: LOCK_STAGES must be at least 2");
   end

   cfg_t                   wr_cfg;
   logic                   en_next;
   logic [LOCK_STAGES-1:0] lock_cnt;

   assign wr_cfg  = cfg_t'(wr_data);
   assign en_next = wr_en ? wr_cfg.pll_en : cfg.pll_en;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         cfg.gear    <= wr_cfg.gear;
         cfg.mul8    <= wr_cfg.mul8;
         cfg.pll_en  <= wr_cfg.pll_en;
         // source select is only accepted once the lock wait has finished
         cfg.sel_pll <= wr_cfg.sel_pll & wr_cfg.pll_en & lock;
      end
   end

   // Lock wait: count starts on the cycle after enable is seen set.
   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_cnt <= '0;
         lock     <= 1'b0;
      end else if (!en_next) begin
         lock_cnt <= '0;
         lock     <= 1'b0;
      end else if (cfg.pll_en && !lock) begin
         if (lock_cnt == '1) begin
            lock <= 1'b1;
         end else begin
            lock_cnt <= lock_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sgc_src_switch.sv
module sgc_src_switch (
   input  logic osc_clk,
   input  logic pll_clk,
   input  logic rst_n,
   input  logic want_pll,
   output logic mux_clk,
   output logic pll_busy
);

   // oscillator side
   logic osc_arm;
   logic osc_gate;
   logic pg_meta;
   logic pg_sync;
   logic pll_req;
   // PLL side
   logic req_meta;
   logic req_sync;
   logic pll_gate;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_meta <= 1'b0;
         pg_sync <= 1'b0;
         osc_arm <= 1'b1;
         pll_req <= 1'b0;
      end else begin
         pg_meta <= pll_gate;
         pg_sync <= pg_meta;
         osc_arm <= ~want_pll & ~pg_sync;
         pll_req <= want_pll & ~osc_gate;
      end
   end

   always_ff @(negedge osc_clk or negedge rst_n) begin
      if (!rst_n) osc_gate <= 1'b1;
      else        osc_gate <= osc_arm;
   end

   always_ff @(posedge pll_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_meta <= 1'b0;
         req_sync <= 1'b0;
      end else begin
         req_meta <= pll_req;
         req_sync <= req_meta;
      end
   end

   always_ff @(negedge pll_clk or negedge rst_n) begin
      if (!rst_n) pll_gate <= 1'b0;
      else        pll_gate <= req_sync;
   end

   assign mux_clk  = (osc_clk & osc_gate) | (pll_clk & pll_gate);
   assign pll_busy = pg_sync | pll_req;

endmodule

// File: rtl/sgc_gear_div.sv
module sgc_gear_div #(
   parameter int DIV_LEVELS = 4,
   parameter int GEAR_W     = 3
) (
   input  logic              mux_clk,
   input  logic              rst_n,
   input  logic [GEAR_W-1:0] gear_code,
   output logic              sys_clk
);

   localparam int CNT_W = DIV_LEVELS - 1;
   localparam int SEL_W = $clog2(DIV_LEVELS);

   if (DIV_LEVELS < 2 || (1 << GEAR_W) < DIV_LEVELS) begin : g_bad_levels
      $error("sgc_gear_div: DIV_LEVELS must be 2..2**GEAR_W");
   end

   logic [GEAR_W-1:0]     code_meta;
   logic [GEAR_W-1:0]     code_sync;
   logic [CNT_W-1:0]      ripple;
   logic [SEL_W-1:0]      act_sel;
   logic [SEL_W-1:0]      next_sel;
   logic [DIV_LEVELS-1:0] cand;

   always_comb begin
      if (int'(code_sync) < DIV_LEVELS) next_sel = code_sync[SEL_W-1:0];
      else                              next_sel = '0;
   end

   always_ff @(posedge mux_clk or negedge rst_n) begin
      if (!rst_n) begin
         code_meta <= '0;
         code_sync <= '0;
         ripple    <= '0;
      end else begin
         code_meta <= gear_code;
         code_sync <= code_meta;
         ripple    <= ripple + 1'b1;
      end
   end

   // At a falling edge with the counter at zero every candidate is low.
   always_ff @(negedge mux_clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel <= '0;
      end else if (ripple == '0 && code_sync == code_meta) begin
         act_sel <= next_sel;
      end
   end

   assign cand[0] = mux_clk;
   for (genvar i = 1; i < DIV_LEVELS; i++) begin : g_cand
      assign cand[i] = ripple[i-1];
   end

   assign sys_clk = cand[act_sel];

endmodule

// File: rtl/sysclk_gear_ctrl.sv
module sysclk_gear_ctrl
   import sgc_pkg::*;
#(
   parameter int LOCK_STAGES = 12,
   parameter int DIV_LEVELS  = 4
) (
   input  logic             osc_clk,
   input  logic             pll_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [RD_W-1:0]  rd_data,
   output logic             pll_on,
   output logic             pll_mul8,
   output logic             sys_clk
);

   cfg_t cfg;
   logic lock;
   logic mux_clk;
   logic pll_busy;

   sgc_cfg_regs #(.LOCK_STAGES(LOCK_STAGES)) u_regs (
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .cfg     (cfg),
      .lock    (lock)
   );

   sgc_src_switch u_switch (
      .osc_clk  (osc_clk),
      .pll_clk  (pll_clk),
      .rst_n    (rst_n),
      .want_pll (cfg.sel_pll),
      .mux_clk  (mux_clk),
      .pll_busy (pll_busy)
   );

   sgc_gear_div #(.DIV_LEVELS(DIV_LEVELS), .GEAR_W(GEAR_W)) u_gear (
      .mux_clk   (mux_clk),
      .rst_n     (rst_n),
      .gear_code (cfg.gear),
      .sys_clk   (sys_clk)
   );

   assign rd_data  = {lock, cfg};
   assign pll_on   = cfg.pll_en | pll_busy;
   assign pll_mul8 = cfg.mul8;

endmodule

// File: rtl/sysclk_gear_ctrl_chk.sv
module sysclk_gear_ctrl_chk (
   input logic       osc_clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [5:0] wr_data,
   input logic [6:0] rd_data,
   input logic       pll_on
);

   // R5: an accepted source select implies the lock flag
   a_r5_sel_needs_lock: assert property (@(posedge osc_clk) disable iff (!rst_n)
      rd_data[5] |-> rd_data[6]);

   // R4: the lock flag never stands without the enable field
   a_r4_lock_needs_en: assert property (@(posedge osc_clk) disable iff (!rst_n)
      rd_data[6] |-> rd_data[4]);

   // R4: the lock flag cannot be set on the cycle the enable appears
   a_r4_no_instant_lock: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $rose(rd_data[4]) |-> !rd_data[6]);

   // R6: select written before lock is dropped
   a_r6_early_sel_ignored: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (wr_en && wr_data[5] && !rd_data[6]) |=> !rd_data[5]);

   // R7: clearing enable clears lock and select at that edge
   a_r7_disable_clears: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (wr_en && !wr_data[4]) |=> (!rd_data[4] && !rd_data[5] && !rd_data[6]));

   // R7: PLL stays requested while it may still drive the output
   a_r7_pll_held: assert property (@(posedge osc_clk) disable iff (!rst_n)
      rd_data[5] |-> pll_on);

   // R10: enable field always requests the PLL
   a_r10_en_drives_pll: assert property (@(posedge osc_clk) disable iff (!rst_n)
      rd_data[4] |-> pll_on);

endmodule

bind sysclk_gear_ctrl sysclk_gear_ctrl_chk u_chk (
   .osc_clk (osc_clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .pll_on  (pll_on)
);

// File: tb/sysclk_gear_ctrl_bench.sv
`timescale 1ns/1ps
module sysclk_gear_ctrl_bench;

   localparam real OSC_PER = 8.0;   // 125 MHz

   logic       osc_clk = 1'b0;
   logic       pll_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic       wr_en   = 1'b0;
   logic [5:0] wr_data = '0;
   logic [6:0] rd_data;
   logic       pll_on;
   logic       pll_mul8;
   logic       sys_clk;

   int compared   = 0;
   int mismatched = 0;
   int runts      = 0;
   int cycles     = 0;
   bit done       = 1'b0;
   bit seen_edge  = 1'b0;
   realtime last_edge = 0;

   sysclk_gear_ctrl u_sysclk_gear_ctrl (
      .osc_clk  (osc_clk),
      .pll_clk  (pll_clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .pll_on   (pll_on),
      .pll_mul8 (pll_mul8),
      .sys_clk  (sys_clk)
   );

   always #(OSC_PER/2.0) osc_clk = ~osc_clk;

   // behavioural PLL: runs while requested, times 6 or times 8
   always begin
      if (pll_on) begin
         pll_clk = 1'b1;
         #(pll_mul8 ? 0.5 : 0.667);
         pll_clk = 1'b0;
         #(pll_mul8 ? 0.5 : 0.667);
      end else begin
         pll_clk = 1'b0;
         @(posedge pll_on);
      end
   end

   // R8 monitor: every sys_clk phase must last at least half a fast period
   always @(sys_clk) begin
      if (rst_n && seen_edge && ($realtime - last_edge) < 0.45) runts++;
      last_edge = $realtime;
      seen_edge = rst_n;
   end

   always @(posedge osc_clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         mismatched++;
         $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   function automatic real exp_period(input bit on_pll, input bit mul8, input logic [2:0] gear);
      real base;
      int  div;
      base = on_pll ? (mul8 ? OSC_PER/8.0 : OSC_PER/6.0) : OSC_PER;
      div  = (gear < 3'd4) ? (1 << gear) : 1;
      return base * div;
   endfunction

   task automatic chk_bits(input string req, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_per(input string req, input real act, input real exp);
      compared++;
      if (act < exp*0.98 || act > exp*1.02) begin
         mismatched++;
         $display("FAIL %s: actual %0.3f ns expected %0.3f ns", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] d);
      @(negedge osc_clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge osc_clk);
      wr_en   = 1'b0;
   endtask

   task automatic meas(output real p);
      realtime t0;
      repeat (30) @(posedge osc_clk);
      @(posedge sys_clk);
      t0 = $realtime;
      @(posedge sys_clk);
      p = $realtime - t0;
   endtask

   initial begin
      real p;
      logic [5:0] d;
      void'($urandom(32'h5eed_c10c));

      repeat (5) @(negedge osc_clk);
      rst_n = 1'b1;
      @(negedge osc_clk);

      // R1 reset state
      chk_bits("R1 rd_data", {1'b0, rd_data}, 8'h00);
      chk_bits("R1 pll_on", {7'd0, pll_on}, 8'h00);
      meas(p);
      chk_per("R1 osc period", p, exp_period(0, 0, 3'd0));

      // R2 and R3: every gear code on the oscillator
      for (int g = 0; g < 8; g++) begin
         wr(6'(g));
         meas(p);
         chk_per(g < 4 ? "R2 gear" : "R3 reserved gear", p, exp_period(0, 0, 3'(g)));
      end

      // R9/R10 random readback with enable toggled, select never accepted
      for (int i = 0; i < 24; i++) begin
         d = 6'($urandom_range(0, 63));
         wr(d);
         chk_bits("R9 readback", {1'b0, rd_data}, {2'b00, 1'b0, d[4:0]});
         chk_bits("R10 pll_on", {7'd0, pll_on}, {7'd0, d[4]});
         if (i % 4 == 0) begin
            meas(p);
            chk_per("R2 random gear", p, exp_period(0, 0, d[2:0]));
         end
      end
      wr(6'h00);
      repeat (20) @(negedge osc_clk);

      // R6: select with enable before lock is ignored; R4 lock timing starts here
      wr(6'b11_1_000);
      chk_bits("R6 select ignored", {7'd0, rd_data[5]}, 8'h00);
      chk_bits("R5 pll_mul8", {7'd0, pll_mul8}, 8'h01);
      repeat (4095) @(posedge osc_clk);
      @(negedge osc_clk);
      chk_bits("R4 lock at 4095", {7'd0, rd_data[6]}, 8'h00);
      @(posedge osc_clk);
      @(negedge osc_clk);
      chk_bits("R4 lock at 4096", {7'd0, rd_data[6]}, 8'h01);
      meas(p);
      chk_per("R6 still on osc", p, exp_period(0, 1, 3'd0));

      // R5: switch to PLL times 8, then several gears and times 6
      wr(6'b11_1_000);
      chk_bits("R5 select accepted", {1'b0, rd_data}, 8'h78);
      meas(p);
      chk_per("R5 pll x8 gear1", p, exp_period(1, 1, 3'd0));
      wr(6'b11_1_001);
      meas(p);
      chk_per("R5 pll x8 gear2", p, exp_period(1, 1, 3'd1));
      wr(6'b11_1_011);
      meas(p);
      chk_per("R5 pll x8 gear8", p, exp_period(1, 1, 3'd3));
      wr(6'b11_0_010);
      chk_bits("R5 pll_mul8 x6", {7'd0, pll_mul8}, 8'h00);
      meas(p);
      chk_per("R5 pll x6 gear4", p, exp_period(1, 0, 3'd2));
      wr(6'b11_0_110);
      meas(p);
      chk_per("R3 reserved on pll", p, exp_period(1, 0, 3'd6));

      // R7: disable returns to oscillator and clears lock
      wr(6'b00_0_010);
      chk_bits("R7 fields cleared", {1'b0, rd_data}, 8'h02);
      repeat (20) @(negedge osc_clk);
      chk_bits("R7 pll_on released", {7'd0, pll_on}, 8'h00);
      meas(p);
      chk_per("R7 back on osc", p, exp_period(0, 0, 3'd2));

      // R7: re-enable waits the full lock time again
      wr(6'b01_1_000);
      repeat (4095) @(posedge osc_clk);
      @(negedge osc_clk);
      chk_bits("R7 relock at 4095", {7'd0, rd_data[6]}, 8'h00);
      @(posedge osc_clk);
      @(negedge osc_clk);
      chk_bits("R7 relock at 4096", {7'd0, rd_data[6]}, 8'h01);
      wr(6'b11_1_001);
      meas(p);
      chk_per("R5 relocked pll", p, exp_period(1, 1, 3'd1));
      wr(6'b00_0_000);
      meas(p);
      chk_per("R7 final osc", p, exp_period(0, 0, 3'd0));

      // R8: no runt phase through all of the above
      chk_bits("R8 runt phases", 8'(runts), 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule